// File: doc/BRIEF.md
# Prescaled Interval Timer

A periodic interrupt source built from a 16-bit down-counter, an 8-bit scale value and a 16-bit period value. An internal prescaler divides the clock by the scale value plus one. Each prescaler tick lowers the counter by one. A tick that finds the counter already at zero raises a single-cycle interrupt pulse and reloads the counter from the period value. A steady stream of interrupts therefore arrives every (period+1)·(scale+1) enabled clock cycles.

Software reaches the three values through a simple write/read port with a two-bit address. A single enable input freezes the whole timing chain while it is low. Writing the count value sets the current count directly and leaves the period alone. Writing the scale value restarts the prescaler phase, so the first interrupt after a setup falls at a predictable cycle.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset the count, period and scale values all read as zero and the interrupt output is low.
- R2: Address 0 selects the count, address 1 the period and address 2 the scale. A write with `wr_en` high takes effect at the next clock edge. The scale keeps only the low 8 bits of `wr_data` and reads back with its upper bits zero.
- R3: The prescaler issues one tick every scale+1 enabled cycles: a scale of 0 ticks every cycle and a scale of 255 ticks every 256 cycles.
- R4: A tick with a nonzero count lowers it by one. A tick with a zero count reloads it from the period value and drives `irq` high for the single cycle after that clock edge, so successive interrupts are (period+1)·(scale+1) enabled cycles apart.
- R5: After a scale write followed by a count write of C, the first interrupt is seen after (C+1)·(scale+1) enabled clock edges.
- R6: A period of 0 gives an interrupt on every tick.
- R7: Writing the count leaves the period value unchanged.
- R8: While `enable` is low, neither the count nor the prescaler phase changes, apart from writes, and `irq` stays low. Counting resumes from the held phase when `enable` returns high.
- R9: A count write in the same cycle as a decrement or a reload wins. The written value is loaded and no interrupt is raised for that cycle.
- R10: A scale write restarts the prescaler phase at zero, whatever phase it held before.
- R11: `irq` is high only in a cycle whose preceding clock edge had `enable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the prescaler and counter when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count, 1 period, 2 scale |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Almost any wrong internal state shows up as an interrupt at the wrong cycle. A prescaler phase that is off by one moves the first interrupt by one cycle. A wrong reload value stretches or shrinks every later interval by a whole multiple of scale+1, so a bad state is exposed by the next interrupt, at most (period+1)·(scale+1) cycles later. The scoreboard compares every pulse against its exact predicted cycle and flags any extra pulse. Read-backs after a hold, a priority collision and a wrap-around confirm that the count stopped exactly where the requirements place it.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Register selectors on the access port
   typedef enum logic [1:0] {
      PIT_SEL_COUNT  = 2'd0,
      PIT_SEL_PERIOD = 2'd1,
      PIT_SEL_SCALE  = 2'd2
   } pit_sel_e;
endpackage

// File: rtl/pit_cfg_regs.sv
module pit_cfg_regs
   import pit_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SCALE_W = 8,
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [CNT_W-1:0]   period_q,
   output logic [SCALE_W-1:0] scale_q,
   output logic               count_wr,
   output logic               scale_wr
);
   logic period_wr;

   assign count_wr  = wr_en && (wr_addr == ADDR_W'(PIT_SEL_COUNT));
   assign period_wr = wr_en && (wr_addr == ADDR_W'(PIT_SEL_PERIOD));
   assign scale_wr  = wr_en && (wr_addr == ADDR_W'(PIT_SEL_SCALE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         scale_q  <= '0;
      end else begin
         if (period_wr) period_q <= wr_data[CNT_W-1:0];
         if (scale_wr)  scale_q  <= wr_data[SCALE_W-1:0];
      end
   end
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int SCALE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               restart,
   input  logic [SCALE_W-1:0] scale,
   output logic [SCALE_W-1:0] phase,
   output logic               tick
);
   logic at_end;

   assign at_end = (phase >= scale);
   assign tick   = enable && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (enable)  phase <= at_end ? '0 : phase + 1'b1;
   end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             irq
);
   logic at_zero;

   assign at_zero = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (load) begin
            count <= load_val;
         end else if (tick) begin
            if (at_zero) begin
               count <= period;
               irq   <= 1'b1;
            end else begin
               count <= count - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer
   import pit_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SCALE_W = 8,
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   generate
      if (DATA_W < CNT_W)   begin : g_bad_cnt   $error("DATA_W must hold the count"); end
      if (DATA_W < SCALE_W) begin : g_bad_scale $error("DATA_W must hold the scale"); end
      if (ADDR_W < 2)       begin : g_bad_addr  $error("ADDR_W must be at least 2");  end
   endgenerate

   logic [CNT_W-1:0]   cnt_val;
   logic [CNT_W-1:0]   period_val;
   logic [SCALE_W-1:0] scale_val;
   logic [SCALE_W-1:0] pre_phase;
   logic               cnt_load;
   logic               scale_load;
   logic               pre_tick;
   logic [DATA_W-1:0]  scale_ext;

   pit_cfg_regs #(
      .CNT_W(CNT_W), .SCALE_W(SCALE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .period_q(period_val), .scale_q(scale_val), .count_wr(cnt_load), .scale_wr(scale_load)
   );

   pit_prescaler #(.SCALE_W(SCALE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .enable(enable), .restart(scale_load),
      .scale(scale_val), .phase(pre_phase), .tick(pre_tick)
   );

   pit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(pre_tick), .load(cnt_load),
      .load_val(wr_data[CNT_W-1:0]), .period(period_val), .count(cnt_val), .irq(irq)
   );

   generate
      if (DATA_W > SCALE_W) begin : g_scale_pad
         assign scale_ext = {{(DATA_W-SCALE_W){1'b0}}, scale_val};
      end else begin : g_scale_full
         assign scale_ext = scale_val;
      end
   endgenerate

   always_comb begin
      unique case (rd_addr)
         ADDR_W'(PIT_SEL_COUNT):  rd_data = DATA_W'(cnt_val);
         ADDR_W'(PIT_SEL_PERIOD): rd_data = DATA_W'(period_val);
         ADDR_W'(PIT_SEL_SCALE):  rd_data = scale_ext;
         default:                 rd_data = '0;
      endcase
   end
endmodule

// File: rtl/pit_checker.sv
module pit_checker
   import pit_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SCALE_W = 8,
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               irq,
   input logic [CNT_W-1:0]   cnt_val,
   input logic [CNT_W-1:0]   period_val,
   input logic [SCALE_W-1:0] scale_val,
   input logic [SCALE_W-1:0] pre_phase
);
   logic cw, pw;
   assign cw = wr_en && (wr_addr == ADDR_W'(PIT_SEL_COUNT));
   assign pw = wr_en && (wr_addr == ADDR_W'(PIT_SEL_PERIOD));

   // R8
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !wr_en) |=> ($stable(cnt_val) && $stable(pre_phase) && !irq));

   // R9
   count_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw |=> (cnt_val == $past(wr_data[CNT_W-1:0]) && !irq));

   // R7
   period_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw |=> $stable(period_val));

   // R4
   reload_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !$past(pw)) |-> (cnt_val == period_val));

   // R3
   prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_phase <= scale_val);

   // R11
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(enable));
endmodule

bind prescaled_interval_timer pit_checker #(
   .CNT_W(CNT_W), .SCALE_W(SCALE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_pit_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .irq(irq), .cnt_val(cnt_val), .period_val(period_val),
   .scale_val(scale_val), .pre_phase(pre_phase)
);

// File: tb/tb_prescaled_interval_timer.sv
`timescale 1ns/1ps
module tb_prescaled_interval_timer;
   localparam int AW = 2;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #4 clk = ~clk;

   prescaled_interval_timer dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   // counts clock edges that saw enable high
   always @(posedge clk) if (enable) cyc <= cyc + 1;

   // monitor: pops the scoreboard on each interrupt pulse
   always @(posedge clk) begin
      int e;
      #2;
      if (rst_n && irq) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R4/R9: unexpected irq at cycle %0d (actual 1, expected 0)", cyc);
         end else begin
            e = exp_q.pop_front();
            if (e != cyc) begin
               errors++;
               $display("FAIL R3/R5: irq at cycle %0d, expected %0d", cyc, e);
            end
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] expv, input string tag);
      rd_addr = a;
      #1;
      checks++;
      if (rd_data !== expv) begin
         errors++;
         $display("FAIL %s: addr %0d read %h, expected %h", tag, a, rd_data, expv);
      end
   endtask

   // driver: program, predict interrupt cycles, run n enabled cycles
   task automatic run(input int s, input int p, input int c, input int n, input string tag);
      int base, e;
      wr(2'd2, DW'(s));   // scale write restarts prescaler (R10)
      wr(2'd1, DW'(p));
      wr(2'd0, DW'(c));
      base = cyc;
      e = (c + 1) * (s + 1);
      while (e <= n) begin
         exp_q.push_back(base + e);
         e += (p + 1) * (s + 1);
      end
      enable = 1'b1;
      repeat (n) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d irq pulses missing (actual %0d left, expected 0)", tag, exp_q.size(), exp_q.size());
         exp_q.delete();
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung (actual timeout, expected completion)");
         report();
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset state
      checks++;
      if (irq !== 1'b0) begin errors++; $display("FAIL R1: irq %b expected 0", irq); end
      rd_chk(2'd0, 16'h0000, "R1 count");
      rd_chk(2'd1, 16'h0000, "R1 period");
      rd_chk(2'd2, 16'h0000, "R1 scale");
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R5: scale 2, period 3, count 1 -> irq at 6,18,30
      run(2, 3, 1, 32, "R4 run A");
      rd_chk(2'd0, 16'd3, "R4 reload value");
      // R6: period 0, scale 0 -> irq every edge
      run(0, 0, 0, 5, "R6 run B");
      // R3: scale 255 divides by 256
      run(255, 1, 0, 800, "R3 run C");
      // R10: prescaler phase left nonzero by run C must restart
      run(1, 4, 3, 20, "R10 run D");

      // R8: hold while disabled, prescaler phase kept
      wr(2'd2, 16'd3); wr(2'd1, 16'd9); wr(2'd0, 16'd5);
      enable = 1'b1;
      repeat (7) @(negedge clk);
      enable = 1'b0;
      repeat (20) @(negedge clk);
      rd_chk(2'd0, 16'd4, "R8 count held");
      enable = 1'b1;
      @(negedge clk);
      enable = 1'b0;
      rd_chk(2'd0, 16'd3, "R8 prescaler phase held");

      // R9: count write collides with zero-count reload
      wr(2'd2, 16'd0); wr(2'd1, 16'd7); wr(2'd0, 16'd2);
      enable = 1'b1;
      repeat (2) @(negedge clk);
      wr(2'd0, 16'h0055);
      enable = 1'b0;
      @(negedge clk);
      rd_chk(2'd0, 16'h0055, "R9 write wins");
      // R7: period untouched by count writes
      rd_chk(2'd1, 16'd7, "R7 period kept");
      // R2: scale keeps low 8 bits only
      wr(2'd2, 16'hABCD);
      rd_chk(2'd2, 16'h00CD, "R2 scale width");
      wr(2'd1, 16'hBEEF);
      rd_chk(2'd1, 16'hBEEF, "R2 period write");
      repeat (3) @(negedge clk);
      done = 1'b1;
      report();
   end
endmodule